// File: doc/BRIEF.md
# Pin Bank Controller with Per-Pin Interrupt Sensing

This block controls a bank of 32 general-purpose pins through a 32-bit word-addressed register port. Software picks each pin's direction with separate set and clear registers. It drives output values through two half-bank registers that carry a per-bit update mask. It reads back the synchronized input levels.

Every pin also feeds an interrupt detector. The detector recognises a rising edge, a falling edge, both edges, a high level or a low level, as chosen by a 4-bit sense code for that pin. The detector runs only while the pin's detect-enable bit is set. Detected events latch into a raw pending vector. That vector is ANDed with an unmask vector and cleared by writing ones. Two request lines summarise the lower and the upper sixteen pins.

The registers sit in two windows. Offsets below 0x40 hold the bank controls. Offsets from 0x40 to 0x4C hold the four sense-configuration words. Reads are combinational from the current register state. Writes take effect at the clock edge on which `reg_wr` is high.

Top module: `gpio_sense_ctrl`

## Requirements
- R1: A write to 0x00 turns every pin whose data bit is 1 into an output. A write to 0x04 turns every pin whose data bit is 1 into an input. Zero bits leave a pin's direction unchanged. Reading 0x00 or 0x04 returns the direction vector on `pin_oe` (1 = output). Reset makes every pin an input.
- R2: A write to 0x08 updates output pin i (0..15) to data bit i only where data bit 16+i is 1. A write to 0x0C does the same for pins 16..31. The other pins keep their values. Each register reads back {16'b0, its half}.
- R3: Reading 0x10 returns the pin inputs after a two-flop synchronizer. A change on `pin_in` is visible there two clock edges later.
- R4: Pin n's sense code sits in bits 4*(n%8)+3..4*(n%8) of the configuration word at 0x40 + 4*(n/8). The codes are: 8 = rising edge, 9 = falling edge, 10 = high level, 11 = low level, 12 = both edges. Every other code, including the reset value 0, detects nothing.
- R5: A detected event sets pin n's raw pending bit only while bit n of the detect-enable register (0x14, read/write) is 1.
- R6: Writing 1s to 0x28 clears those raw pending bits. Zero bits leave pending bits unchanged. Reading 0x20 returns the raw pending vector.
- R7: A write of 1s to 0x18 unmasks those pins, and a write of 1s to 0x1C masks them. Reading 0x1C returns the unmask vector. Reading 0x24 returns raw pending AND unmask. `irq_lo` is the OR of masked bits 15:0, and `irq_hi` is the OR of masked bits 31:16.
- R8: In a level mode the pending bit is set again on every cycle that the level persists. A clear issued while the level holds leaves the bit set.
- R9: An edge on `pin_in` sets the pending bit three clock edges after the input changes, and not earlier.
- R10: Offsets from 0x40 to 0x4C read back the configuration words written there. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pin_in | input | 32 | Asynchronous pin input levels |
| pin_out | output | 32 | Output values |
| pin_oe | output | 32 | Output enables (1 = drive) |
| irq_lo | output | 1 | Request for pins 0..15 |
| irq_hi | output | 1 | Request for pins 16..31 |

## Verification
The results of a register write, such as direction, output values, masks, configuration and clearing, appear one edge after the write and are read at the following falling edge. Synchronized input levels appear two edges after `pin_in` changes, and a detected event reaches pending and the request lines on the third edge. The bench therefore drives pins at a falling edge and waits four falling edges before it compares. The latency check samples at exactly the second and the third edge, to pin the depth down. Each sense sweep steps through every pin and every code and predicts the pending bit after each phase of input, clearing and disabling.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
    localparam int NPIN     = 32;
    localparam int HALF     = NPIN / 2;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int CODE_W   = 4;
    localparam int CFG_REGS = NPIN * CODE_W / DATA_W;

    localparam logic [ADDR_W-1:0] OFS_DIR_SET = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR_CLR = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_OUT_LO  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_OUT_HI  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_LEVELS  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_DET_EN  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_UNM_SET = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_UNM_CLR = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_RAW     = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_MASKED  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_ACK     = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_CFG0    = 8'h40;

    typedef enum logic [CODE_W-1:0] {
        SNS_RISE = 4'd8,
        SNS_FALL = 4'd9,
        SNS_HIGH = 4'd10,
        SNS_LOW  = 4'd11,
        SNS_BOTH = 4'd12
    } sense_e;

    typedef struct packed {
        logic [NPIN-1:0] cur;
        logic [NPIN-1:0] prev;
    } pin_sample_t;

    // second window holds the configuration words
    function automatic logic in_cfg_window(logic [ADDR_W-1:0] a);
        return (a >= OFS_CFG0) && (a < OFS_CFG0 + 8'(CFG_REGS * 4));
    endfunction

    function automatic logic sense_hit(logic [CODE_W-1:0] code, logic cur, logic prev);
        case (code)
            SNS_RISE: return cur & ~prev;
            SNS_FALL: return ~cur & prev;
            SNS_HIGH: return cur;
            SNS_LOW:  return ~cur;
            SNS_BOTH: return cur ^ prev;
            default:  return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/gsc_sync.sv
module gsc_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out,
    output logic [WIDTH-1:0] sync_prev
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[k] <= '0;
                    else     stage_q[k] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[k] <= '0;
                    else     stage_q[k] <= stage_q[k-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sync_prev <= '0;
        else     sync_prev <= stage_q[STAGES-1];
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gsc_detect.sv
module gsc_detect
    import gsc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  pin_sample_t            smp,
    input  logic [NPIN-1:0]        det_en,
    input  logic [NPIN*CODE_W-1:0] sense,
    input  logic [NPIN-1:0]        ack,
    output logic [NPIN-1:0]        pend
);
    logic [NPIN-1:0] hit;

    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_pin
            assign hit[g] = det_en[g] &
                            sense_hit(sense[g*CODE_W +: CODE_W], smp.cur[g], smp.prev[g]);
        end
    endgenerate

    // a new hit wins over an acknowledge in the same cycle
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~ack) | hit;
    end
endmodule

// File: rtl/gsc_regs.sv
module gsc_regs
    import gsc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    input  logic [NPIN-1:0]        levels,
    input  logic [NPIN-1:0]        pend,
    output logic [NPIN-1:0]        dir_q,
    output logic [NPIN-1:0]        out_q,
    output logic [NPIN-1:0]        det_en_q,
    output logic [NPIN-1:0]        unmask_q,
    output logic [NPIN*CODE_W-1:0] sense_q,
    output logic [NPIN-1:0]        ack,
    output logic [NPIN-1:0]        masked
);
    localparam int CFG_IDX_W = $clog2(CFG_REGS);

    logic [HALF-1:0] wmask, wval;
    logic [CFG_IDX_W-1:0] cfg_idx;

    assign wmask   = reg_wdata[DATA_W-1:HALF];
    assign wval    = reg_wdata[HALF-1:0];
    assign cfg_idx = reg_addr[CFG_IDX_W+1:2];
    assign masked  = pend & unmask_q;
    assign ack     = (reg_wr && reg_addr == OFS_ACK) ? reg_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q    <= '0;
            out_q    <= '0;
            det_en_q <= '0;
            unmask_q <= '0;
            sense_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_DIR_SET: dir_q    <= dir_q | reg_wdata;
                OFS_DIR_CLR: dir_q    <= dir_q & ~reg_wdata;
                OFS_OUT_LO:  out_q[HALF-1:0]    <= (out_q[HALF-1:0] & ~wmask) | (wval & wmask);
                OFS_OUT_HI:  out_q[NPIN-1:HALF] <= (out_q[NPIN-1:HALF] & ~wmask) | (wval & wmask);
                OFS_DET_EN:  det_en_q <= reg_wdata;
                OFS_UNM_SET: unmask_q <= unmask_q | reg_wdata;
                OFS_UNM_CLR: unmask_q <= unmask_q & ~reg_wdata;
                default: begin
                    if (in_cfg_window(reg_addr))
                        sense_q[cfg_idx*DATA_W +: DATA_W] <= reg_wdata;
                end
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_DIR_SET, OFS_DIR_CLR: reg_rdata = dir_q;
            OFS_OUT_LO:  reg_rdata = {{HALF{1'b0}}, out_q[HALF-1:0]};
            OFS_OUT_HI:  reg_rdata = {{HALF{1'b0}}, out_q[NPIN-1:HALF]};
            OFS_LEVELS:  reg_rdata = levels;
            OFS_DET_EN:  reg_rdata = det_en_q;
            OFS_UNM_CLR: reg_rdata = unmask_q;
            OFS_RAW:     reg_rdata = pend;
            OFS_MASKED:  reg_rdata = masked;
            default: begin
                if (in_cfg_window(reg_addr))
                    reg_rdata = sense_q[cfg_idx*DATA_W +: DATA_W];
            end
        endcase
    end
endmodule

// File: rtl/gpio_sense_ctrl.sv
module gpio_sense_ctrl
    import gsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] pin_in,
    output logic [31:0] pin_out,
    output logic [31:0] pin_oe,
    output logic        irq_lo,
    output logic        irq_hi
);
    pin_sample_t smp;
    logic [NPIN-1:0] pend_q, det_en_q, unmask_q, ack, masked;
    logic [NPIN*CODE_W-1:0] sense_q;

    gsc_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(pin_in),
        .sync_out(smp.cur), .sync_prev(smp.prev)
    );

    gsc_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .levels(smp.cur), .pend(pend_q),
        .dir_q(pin_oe), .out_q(pin_out), .det_en_q(det_en_q),
        .unmask_q(unmask_q), .sense_q(sense_q), .ack(ack), .masked(masked)
    );

    gsc_detect u_detect (
        .clk(clk), .rst(rst), .smp(smp), .det_en(det_en_q),
        .sense(sense_q), .ack(ack), .pend(pend_q)
    );

    assign irq_lo = |masked[HALF-1:0];
    assign irq_hi = |masked[NPIN-1:HALF];
endmodule

// File: rtl/gsc_checker.sv
module gsc_checker
    import gsc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] pin_out,
    input logic [31:0] pin_oe,
    input logic [31:0] pend,
    input logic [31:0] det_en,
    input logic [31:0] unmask,
    input logic        irq_lo,
    input logic        irq_hi
);
    assert_dir_set_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_DIR_SET) |=> ((pin_oe & $past(reg_wdata)) == $past(reg_wdata)));

    assert_dir_clr_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_DIR_CLR) |=> ((pin_oe & $past(reg_wdata)) == '0));

    assert_out_lo_keeps_hi_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_OUT_LO) |=> (pin_out[31:16] == $past(pin_out[31:16])));

    assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (det_en == '0 && pend == '0) |=> (pend == '0));

    assert_ack_all_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_ACK && reg_wdata == '1 && det_en == '0) |=> (pend == '0));

    assert_req_needs_unmask_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_lo || irq_hi) |-> (unmask != '0 && pend != '0));
endmodule

bind gpio_sense_ctrl gsc_checker u_gsc_checker (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
    .pend(pend_q), .det_en(det_en_q), .unmask(unmask_q),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/gpio_sense_ctrl_bench.sv
module gpio_sense_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq_lo, irq_hi;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    gpio_sense_ctrl u_gpio_sense_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d, mdir, mout, exp_p;
        logic [15:0] mk, vl;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);

        // reset state
        rd(8'h04, d); chk("R1 reset dir", d, 0);
        chk("R1 reset oe", pin_oe, 0);
        rd(8'h20, d); chk("R6 reset pend", d, 0);
        chk("R7 reset irq", {30'b0, irq_hi, irq_lo}, 0);

        // R1 direction sweep
        mdir = 0;
        for (int i = 0; i < 32; i++) begin
            wr(8'h00, 32'h1 << i); mdir |= 32'h1 << i;
            chk("R1 set", pin_oe, mdir);
        end
        for (int i = 0; i < 32; i += 3) begin
            wr(8'h04, 32'h5 << i); mdir &= ~(32'h5 << i);
            rd(8'h00, d); chk("R1 clr", d, mdir);
        end
        wr(8'h04, 32'h0);
        rd(8'h04, d); chk("R1 zero no effect", d, mdir);

        // R2 masked output writes
        mout = 0;
        for (int i = 0; i < 12; i++) begin
            mk = 16'(32'h9E37 * (i + 1)); vl = 16'(32'h7F4A * (i + 3));
            wr(8'h08, {mk, vl});
            mout[15:0] = (mout[15:0] & ~mk) | (vl & mk);
            chk("R2 out lo", pin_out, mout);
            wr(8'h0C, {vl, mk});
            mout[31:16] = (mout[31:16] & ~vl) | (mk & vl);
            chk("R2 out hi", pin_out, mout);
            rd(8'h0C, d); chk("R2 read hi", d, {16'b0, mout[31:16]});
        end

        // R3 input levels
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); pin_in = 32'hA5C3_0F96 ^ (32'h1111_1111 * i);
            wait_n(2);
            rd(8'h10, d); chk("R3 levels", d, pin_in);
        end
        @(negedge clk); pin_in = 0; wait_n(4);

        // R10 configuration window and unmapped offsets
        for (int k = 0; k < 4; k++) wr(8'h40 + 8'(4 * k), 32'h1234_5678 + 32'(k));
        for (int k = 0; k < 4; k++) begin
            rd(8'h40 + 8'(4 * k), d); chk("R10 cfg readback", d, 32'h1234_5678 + 32'(k));
        end
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h50, d); chk("R10 unmapped", d, 0);
        rd(8'h2C, d); chk("R10 unmapped low", d, 0);
        for (int k = 0; k < 4; k++) wr(8'h40 + 8'(4 * k), 0);

        // R4/R5/R6/R8 sweep over pins and codes
        wr(8'h18, 32'hFFFF_FFFF);
        for (int n = 0; n < 32; n++) begin
            for (int c = 0; c < 7; c++) begin
                int code;
                logic ea, eb, eb2, ec, r, f, hi, lo, bo;
                code = (c < 5) ? 8 + c : (c == 5 ? 0 : 13);
                r = code == 8; f = code == 9; hi = code == 10; lo = code == 11; bo = code == 12;
                wr(8'h40 + 8'(4 * (n / 8)), 32'(code) << (4 * (n % 8)));
                wr(8'h14, 32'h1 << n);
                wr(8'h28, 32'hFFFF_FFFF);
                ea = lo;
                rd(8'h20, d); chk("R4 phase low", d, 32'(ea) << n);
                @(negedge clk); pin_in[n] = 1'b1; wait_n(4);
                eb = ea | r | hi | bo;
                rd(8'h20, d); chk("R4 phase rise", d, 32'(eb) << n);
                chk("R7 irq lines", {30'b0, irq_hi, irq_lo},
                    eb ? (n < 16 ? 32'd1 : 32'd2) : 32'd0);
                wr(8'h28, 32'h1 << n);
                eb2 = hi;
                rd(8'h20, d); chk("R8 clear under level", d, 32'(eb2) << n);
                @(negedge clk); pin_in[n] = 1'b0; wait_n(4);
                ec = eb2 | f | bo | lo;
                rd(8'h20, d); chk("R4 phase fall", d, 32'(ec) << n);
                wr(8'h14, 0);
                wr(8'h28, 32'hFFFF_FFFF);
                rd(8'h20, d); chk("R6 ack all", d, 0);
                @(negedge clk); pin_in[n] = 1'b1; wait_n(4);
                rd(8'h20, d); chk("R5 disabled", d, 0);
                @(negedge clk); pin_in[n] = 1'b0; wait_n(4);
                rd(8'h20, d); chk("R5 disabled low", d, 0);
            end
            wr(8'h40 + 8'(4 * (n / 8)), 0);
        end

        // R9 latency and R7 masking
        wr(8'h40, 32'h8 << 8);
        wr(8'h48, 32'h8 << 16);
        wr(8'h14, 32'h0010_0004);
        wr(8'h1C, 32'hFFFF_FFFF);
        @(negedge clk); pin_in = 32'h0010_0004;
        wait_n(2);
        rd(8'h20, d); chk("R9 not yet", d, 0);
        wait_n(1);
        rd(8'h20, d); chk("R9 due", d, 32'h0010_0004);
        rd(8'h24, d); chk("R7 all masked", d, 0);
        chk("R7 irq masked", {30'b0, irq_hi, irq_lo}, 0);
        wr(8'h18, 32'h0010_0000);
        rd(8'h24, d); chk("R7 masked hi", d, 32'h0010_0000);
        chk("R7 irq hi only", {30'b0, irq_hi, irq_lo}, 2);
        wr(8'h18, 32'h0000_0004);
        chk("R7 irq both", {30'b0, irq_hi, irq_lo}, 3);
        wr(8'h1C, 32'h0010_0000);
        rd(8'h1C, d); chk("R7 unmask read", d, 32'h4);
        chk("R7 irq lo only", {30'b0, irq_hi, irq_lo}, 1);
        wr(8'h28, 32'h0000_0004);
        exp_p = 32'h0010_0000;
        rd(8'h20, d); chk("R6 partial ack", d, exp_p);
        chk("R7 irq none", {30'b0, irq_hi, irq_lo}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule